// File: doc/BRIEF.md
# Ones-Complement Block Checksum Engine

This block computes the 16-bit ones-complement checksum used by common internet transport and network headers. It takes a stream of 16-bit words, one per cycle when the word strobe is high. It adds them with end-around carry, and when the end-of-block strobe arrives it presents the inverted sum as the checksum. The same datapath checks incoming blocks. The receiver streams the data words followed by the checksum it received, and the block raises a pass flag when the accumulated total comes out all ones.

A block begins with a start strobe, which empties the accumulator. Words follow, with idle cycles allowed between them. The block closes with an end strobe. A word may share a cycle with either strobe, and it is then counted in that block. The mode input is sampled in the end-strobe cycle. The checksum and flag are registered, appear one cycle after the end strobe, and stay until the next end strobe. Parsing packets and building pseudo-headers are left to the surrounding logic.

Top module: `csum_unit`

## Requirements
- R1: While reset is applied and until the first end strobe, `csum_vld`, `csum_ok` and `csum_out` are all zero.
- R2: Words are added as unsigned 16-bit numbers, and a carry out of bit 15 is added back in at bit 0, so the running sum stays 16 bits (for example 0xFFFF + 0x0001 gives 0x0001, and 0x8000 + 0x8000 gives 0x0001).
- R3: `blk_start` empties the running sum. A word presented in the same cycle becomes the first term of the new block, and anything accumulated earlier is discarded.
- R4: A cycle with `word_vld` low leaves the running sum unchanged, whatever value is on `word_in`.
- R5: One cycle after a cycle with `blk_end` high, `csum_vld` is high for that one cycle, and `csum_out` holds the bitwise inverse of the block's sum. The sum includes a word presented in the `blk_end` cycle.
- R6: `verify_mode` is sampled with `blk_end`; 1 selects check and 0 selects generate. In check mode `csum_ok` is 1 exactly when the block's sum is 0xFFFF. In generate mode `csum_ok` is 0.
- R7: `csum_out` and `csum_ok` hold their values until the next `blk_end`, and `csum_vld` is low in cycles that do not follow a `blk_end`.
- R8: The block 0x0001, 0xF203, 0xF4F5, 0xF6F7 sums to 0xDDF2, so it yields checksum 0x220D. Those four words followed by 0x220D, in check mode, give `csum_ok` = 1.
- R9: A block with no words has sum 0x0000 and yields checksum 0xFFFF; in check mode it gives `csum_ok` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| blk_start | input | 1 | Start of block; empties the running sum |
| word_vld | input | 1 | `word_in` carries a word to add this cycle |
| word_in | input | 16 | Data word, or the received checksum in check mode |
| blk_end | input | 1 | End of block; latches the result |
| verify_mode | input | 1 | 1 = check a received block, 0 = generate a checksum |
| csum_out | output | 16 | Inverted ones-complement sum of the last finished block |
| csum_vld | output | 1 | One-cycle pulse, one cycle after `blk_end` |
| csum_ok | output | 1 | Check passed (running sum equal to 0xFFFF) |

## Verification
The bench targets several boundary cases, each tied to a typical fault:
- **Carry wrap.** Word pairs whose sum overflows bit 15, such as 0xFFFF with 0x0001 and 0x8000 with 0x8000, check the end-around carry. A design that drops the carry is off by one on such blocks.
- **All-ones words.** Blocks made only of 0xFFFF words check that the negative-zero value survives repeated addition. A design that folds the carry wrongly would let the sum drop to 0x0000, so a check that should pass would fail.
- **Words sharing a strobe cycle.** Words placed in the same cycle as the start or end strobe are counted. A design that ignored them would return a checksum one word short.
- **Restart and empty blocks.** A restart after stray accumulation, and an empty block, catch a clear that leaks the earlier sum.
- **Strobe traffic.** Idle cycles with noise on the data bus, and later start strobes, show whether the result register is disturbed between blocks.

// File: rtl/csum_pkg.sv
package csum_pkg;

  localparam int unsigned CSUM_W = 16;

  typedef enum logic {
    MODE_GEN = 1'b0,
    MODE_CHK = 1'b1
  } csum_mode_e;

endpackage

// File: rtl/csum_rst_sync.sv
module csum_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/csum_ones_add.sv
module csum_ones_add #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  output logic [W-1:0] sum
);

  localparam int unsigned EXT_W = W + 1;

  logic [EXT_W-1:0] raw;
  logic [W-1:0]     wrapped;

  always_comb begin
    raw     = {1'b0, op_a} + {1'b0, op_b};
    // the low part is at most 2^W-2 when a carry occurred, so one fold suffices
    wrapped = raw[W-1:0] + {{(W-1){1'b0}}, raw[W]};
    sum     = wrapped;
  end

  always_comb begin
    if ((op_a != '0 || op_b != '0) && sum == '0) begin
      $error("p_nonzero_sum_r2: nonzero operands produced zero");
    end
  end

endmodule

// File: rtl/csum_accum.sv
module csum_accum
  import csum_pkg::*;
#(
  parameter int unsigned W = CSUM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         add_en,
  input  logic [W-1:0] word,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] acc_nxt
);

  logic [W-1:0] base;
  logic [W-1:0] added;
  logic [W-1:0] acc_d;
  logic         acc_en;

  csum_ones_add #(.W(W)) add_i (
    .op_a (base),
    .op_b (word),
    .sum  (added)
  );

  always_comb begin
    base    = clr ? '0 : acc_q;
    acc_d   = add_en ? added : base;
    acc_en  = clr | add_en;
    acc_nxt = acc_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !add_en) |=> (acc_q == '0));

  p_start_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && add_en) |=> (acc_q == $past(word)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(acc_q));

  p_no_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && add_en && acc_q != '0) |=> (acc_q != '0));

endmodule

// File: rtl/csum_result.sv
module csum_result
  import csum_pkg::*;
#(
  parameter int unsigned W = CSUM_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture,
  input  csum_mode_e   mode,
  input  logic [W-1:0] sum_in,
  output logic [W-1:0] csum_q,
  output logic         ok_q,
  output logic         vld_q
);

  localparam logic [W-1:0] ALL_ONES = '1;

  logic [W-1:0] csum_d;
  logic         ok_d;
  logic         vld_d;

  always_comb begin
    csum_d = csum_q;
    ok_d   = ok_q;
    vld_d  = capture;
    if (capture) begin
      csum_d = ~sum_in;
      ok_d   = (mode == MODE_CHK) && (sum_in == ALL_ONES);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csum_q <= '0;
      ok_q   <= 1'b0;
      vld_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      if (capture) begin
        csum_q <= csum_d;
        ok_q   <= ok_d;
      end
    end
  end

  p_vld_follows_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> vld_q);

  p_vld_only_after_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> !vld_q);

  p_ok_means_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ok_q |-> (csum_q == '0));

  p_gen_no_ok_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && mode == MODE_GEN) |=> !ok_q);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !capture |=> ($stable(csum_q) && $stable(ok_q)));

endmodule

// File: rtl/csum_unit.sv
module csum_unit
  import csum_pkg::*;
#(
  parameter int unsigned W         = CSUM_W,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         blk_start,
  input  logic         word_vld,
  input  logic [W-1:0] word_in,
  input  logic         blk_end,
  input  logic         verify_mode,
  output logic [W-1:0] csum_out,
  output logic         csum_vld,
  output logic         csum_ok
);

  logic         rst_n_s;
  logic [W-1:0] acc_q;
  logic [W-1:0] acc_nxt;
  csum_mode_e   mode;

  assign mode = verify_mode ? MODE_CHK : MODE_GEN;

  csum_rst_sync #(.STAGES(RST_STAGES)) rst_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  csum_accum #(.W(W)) acc_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .clr     (blk_start),
    .add_en  (word_vld),
    .word    (word_in),
    .acc_q   (acc_q),
    .acc_nxt (acc_nxt)
  );

  csum_result #(.W(W)) res_i (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .capture (blk_end),
    .mode    (mode),
    .sum_in  (acc_nxt),
    .csum_q  (csum_out),
    .ok_q    (csum_ok),
    .vld_q   (csum_vld)
  );

  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(rst_n_s) |-> (!csum_vld && !csum_ok));

endmodule

// File: tb/csum_unit_tb_top.sv
module csum_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        blk_start;
  logic        word_vld;
  logic [15:0] word_in;
  logic        blk_end;
  logic        verify_mode;
  logic [15:0] csum_out;
  logic        csum_vld;
  logic        csum_ok;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  logic [15:0] blk [0:39];
  int          blk_n;

  always #10 clk = ~clk;

  csum_unit dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .blk_start   (blk_start),
    .word_vld    (word_vld),
    .word_in     (word_in),
    .blk_end     (blk_end),
    .verify_mode (verify_mode),
    .csum_out    (csum_out),
    .csum_vld    (csum_vld),
    .csum_ok     (csum_ok)
  );

  function automatic logic [15:0] ref_sum(input int n);
    longint unsigned t = 0;
    longint unsigned m;
    for (int i = 0; i < n; i++) t += blk[i];
    if (t == 0) return 16'h0000;
    m = t % 65535;
    return (m == 0) ? 16'hFFFF : m[15:0];
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic s, input logic v, input logic [15:0] w,
                       input logic e, input logic m);
    @(negedge clk);
    blk_start   = s;
    word_vld    = v;
    word_in     = w;
    blk_end     = e;
    verify_mode = m;
  endtask

  task automatic run_block(input bit mode, input bit at_start, input bit at_end,
                           input bit gaps, input string req);
    int idx = 0;
    logic [15:0] s;
    logic [15:0] prev;
    s = ref_sum(blk_n);
    if (at_start && blk_n > 0) begin
      drive(1, 1, blk[0], (blk_n == 1) && at_end, mode);
      idx = 1;
    end else begin
      drive(1, 0, 16'($urandom), 0, mode);
    end
    while (idx < blk_n) begin
      if (gaps && ($urandom % 3 == 0)) drive(0, 0, 16'($urandom), 0, mode);
      drive(0, 1, blk[idx], (idx == blk_n - 1) && at_end, mode);
      idx++;
    end
    if (!(at_end && blk_n > 0)) drive(0, 0, 16'($urandom), 1, mode);
    drive(0, 0, 16'($urandom), 0, ~mode);
    check(req, "csum_vld pulse (R5)", {15'b0, csum_vld}, 16'h0001);
    check(req, "csum_out (R5)", csum_out, ~s);
    check(req, "csum_ok (R6)", {15'b0, csum_ok}, {15'b0, mode && (s == 16'hFFFF)});
    prev = csum_out;
    drive(0, 0, 16'($urandom), 0, ~mode);
    check("R7", "csum_vld low after pulse", {15'b0, csum_vld}, 16'h0000);
    check("R7", "csum_out held", csum_out, prev);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    logic        held_ok;
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; blk_start = 0; word_vld = 0; word_in = 0; blk_end = 0; verify_mode = 0;
    repeat (3) @(negedge clk);
    check("R1", "csum_vld in reset", {15'b0, csum_vld}, 16'h0);
    check("R1", "csum_out in reset", csum_out, 16'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "csum_vld after reset", {15'b0, csum_vld}, 16'h0);
    check("R1", "csum_ok after reset", {15'b0, csum_ok}, 16'h0);
    check("R1", "csum_out after reset", csum_out, 16'h0);

    // R8 known block, generate then check
    blk[0] = 16'h0001; blk[1] = 16'hF203; blk[2] = 16'hF4F5; blk[3] = 16'hF6F7; blk_n = 4;
    check("R8", "reference sum", ref_sum(4), 16'hDDF2);
    run_block(0, 0, 0, 0, "R8");
    check("R8", "checksum value", csum_out, 16'h220D);
    blk[4] = 16'h220D; blk_n = 5;
    run_block(1, 1, 1, 1, "R8");
    check("R8", "verify pass", {15'b0, csum_ok}, 16'h0001);

    // R2 end-around carry
    blk[0] = 16'hFFFF; blk[1] = 16'h0001; blk_n = 2;
    run_block(0, 1, 1, 0, "R2");
    check("R2", "FFFF+0001", csum_out, 16'hFFFE);
    blk[0] = 16'h8000; blk[1] = 16'h8000; blk_n = 2;
    run_block(0, 0, 1, 0, "R2");
    check("R2", "8000+8000", csum_out, 16'hFFFE);
    for (int i = 0; i < 6; i++) blk[i] = 16'hFFFF;
    blk_n = 6;
    run_block(1, 1, 0, 0, "R2");
    check("R2", "all-ones block passes", {15'b0, csum_ok}, 16'h0001);

    // R9 empty block
    blk_n = 0;
    run_block(1, 0, 0, 0, "R9");
    check("R9", "empty checksum", csum_out, 16'hFFFF);
    check("R9", "empty no pass", {15'b0, csum_ok}, 16'h0000);

    // R3 restart discards stray sum; R4 noise with valid low
    drive(1, 1, 16'h1234, 0, 0);
    drive(0, 1, 16'hABCD, 0, 0);
    drive(0, 0, 16'hFFFF, 0, 0);
    blk[0] = 16'h0100; blk[1] = 16'h0020; blk_n = 2;
    run_block(0, 1, 0, 1, "R3");
    check("R3", "restart result", csum_out, 16'hFEDF);
    drive(1, 0, 16'h7777, 0, 0);
    drive(0, 0, 16'h5555, 0, 0);
    drive(0, 0, 16'hAAAA, 1, 0);
    drive(0, 0, 16'h0000, 0, 0);
    check("R4", "invalid words ignored", csum_out, 16'hFFFF);

    // R7 hold under traffic without blk_end
    held = csum_out; held_ok = csum_ok;
    drive(1, 1, 16'h1111, 0, 1);
    drive(0, 1, 16'h2222, 0, 1);
    drive(0, 0, 16'h3333, 0, 0);
    check("R7", "csum_out held under traffic", csum_out, held);
    check("R7", "csum_ok held", {15'b0, csum_ok}, {15'b0, held_ok});
    check("R7", "no pulse without end", {15'b0, csum_vld}, 16'h0);

    // R6 generate mode never passes even on FFFF sum
    blk[0] = 16'hF0F0; blk[1] = 16'h0F0F; blk_n = 2;
    run_block(0, 1, 1, 0, "R6");
    check("R6", "gen mode ok low", {15'b0, csum_ok}, 16'h0000);

    // random blocks: generate, then verify good and corrupted copies
    for (int r = 0; r < 60; r++) begin
      logic [15:0] c;
      blk_n = 1 + ($urandom % 30);
      for (int i = 0; i < blk_n; i++) blk[i] = 16'($urandom);
      c = ~ref_sum(blk_n);
      run_block(0, bit'($urandom), bit'($urandom), 1, "R5");
      check("R5", "random checksum", csum_out, c);
      blk[blk_n] = c; blk_n++;
      run_block(1, bit'($urandom), bit'($urandom), 1, "R6");
      blk[$urandom % blk_n] ^= 16'(1 << ($urandom % 16));
      run_block(1, bit'($urandom), bit'($urandom), 1, "R6");
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule